// File: doc/BRIEF.md
# Bitwise Bus Arbitration Unit for a Wired-AND Serial Bus

This block lets one node compete for a shared serial bus on which a low level overrides a high level. Logic 0 is the dominant level and logic 1 the recessive level; when nodes drive both at once, the bus carries 0. An external bit timer delivers a single-cycle `sample_stb` at each bit's sample point, together with the sampled bus level `bus_bit`. All decisions are taken on those strobes and nowhere else.

The unit tracks runs of recessive samples to decide when the bus is free. While the bus is free, a pending `tx_req` lets the node drive its start-of-frame bit, which is dominant. For the twelve bits that follow (an 11-bit identifier, most significant bit first, then the remote-request bit), the unit compares what the node sends with what the bus shows. A node that sends recessive but reads dominant has met a higher-priority message, which is one with a lower identifier. That node drops its drive without disturbing the winner, listens, and may try again once the bus is free. A dominant bit that reads back recessive is reported as a bit error and does not count as an arbitration loss. The frame serializer upstream is expected to stuff bits, so that no frame carries eleven recessive bits in a row before its end.

Top module: `can_arb_unit`

## Requirements
- R1: After reset, `tx_enable`, `bus_idle`, `arb_lost` and `bit_err` are 0 and `drive_bit` is 1 (recessive).
- R2: `bus_idle` rises in the clock after the strobe that samples the 11th consecutive recessive bit (`bus_bit`=1). It does not rise after only 10. Any strobe that samples a dominant bit restarts the count.
- R3: A dominant sample taken while `bus_idle` is 1 clears `bus_idle` in the clock after that strobe.
- R4: `tx_req` takes effect only while `bus_idle` is 1. In that case `tx_enable` is 1 and `drive_bit` is 0 (the start-of-frame bit) at once, and the next strobe starts the frame. When `bus_idle` is 0, `tx_req` leaves `tx_enable` at 0 and `drive_bit` at 1.
- R5: Arbitration covers the 12 strobes that follow the start-of-frame strobe. A strobe in that window that has `tx_bit`=1 and `bus_bit`=0 makes `arb_lost` high for exactly one clock after it, and `tx_enable` falls in that same clock.
- R6: After a loss, `drive_bit` stays 1 whatever `tx_bit` is, until the bus is idle again. After that, a new `tx_req` starts a frame.
- R7: While the node drives a dominant bit, a strobe with `bus_bit`=1 makes `bit_err` high for one clock. It gives no `arb_lost`, and the node keeps transmitting.
- R8: After the arbitration window, sending recessive and reading dominant (for example in the acknowledge slot) raises neither `arb_lost` nor `bit_err`, and `tx_enable` stays 1.
- R9: A node whose identifier is lower than every competitor's keeps `tx_enable` at 1 through arbitration, and `drive_bit` follows `tx_bit`.
- R10: A transmitting node ends its frame when it samples 11 consecutive recessive bits. `tx_enable` falls and `bus_idle` rises in the clock after that strobe.
- R11: Changes on `bus_bit` between strobes have no effect. `bus_idle` and the frame state stay as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_stb | input | 1 | Single-cycle bit sample strobe from the bit timer |
| bus_bit | input | 1 | Sampled bus level (0 dominant) |
| tx_req | input | 1 | Node has a frame ready to start |
| tx_bit | input | 1 | Node's current bit from the serializer after start of frame |
| drive_bit | output | 1 | Level the node puts on the bus (1 when not driving) |
| tx_enable | output | 1 | Node is allowed to drive the bus |
| bus_idle | output | 1 | Bus counted free |
| arb_lost | output | 1 | One-clock pulse on loss of arbitration |
| bit_err | output | 1 | One-clock pulse on dominant sent, recessive read |

## Verification
The hardest case to reach is a loss of arbitration at an exact bit position. The most delicate one is a loss on the remote-request bit when two identifiers are equal. The bench models a second node and forms the bus as the AND of both drives. It also models that node dropping out when it loses, so identifier pairs chosen to differ at a known bit place the loss on a known strobe. A bit error cannot occur on a wired-AND bus built this way, so the bench has an override that forces a recessive read under a dominant drive.

// File: rtl/can_arb_pkg.sv
// Shared types for the bus arbitration unit.
package can_arb_pkg;

    // Node role on the bus.
    typedef enum logic [1:0] {
        ST_LISTEN = 2'd0,   // waiting for a free bus, not driving
        ST_IDLE   = 2'd1,   // bus free, may start a frame
        ST_TX     = 2'd2    // own frame in progress
    } arb_state_t;

endpackage

// File: rtl/can_arb_idle_det.sv
// Recessive-run detector.
// Counts consecutive recessive samples (saturating at IDLE_BITS). Reports
// combinationally, on the strobe that completes the run, that the bus has
// become free. Assumes sample_stb is a single-cycle strobe.
module can_arb_idle_det #(
    parameter int IDLE_BITS = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sample_stb,
    input  logic bus_bit,
    output logic run_fill
);
    localparam int CW = $clog2(IDLE_BITS + 1);
    localparam logic [CW-1:0] FULL = CW'(IDLE_BITS);
    localparam logic [CW-1:0] LAST = CW'(IDLE_BITS - 1);

    logic [CW-1:0] run_cnt;

    // Run counter: dominant restarts, recessive counts up to saturation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (sample_stb) begin
            if (!bus_bit)
                run_cnt <= '0;
            else if (run_cnt != FULL)
                run_cnt <= run_cnt + 1'b1;
        end
    end

    // Run complete on this strobe.
    always_comb begin
        run_fill = sample_stb && bus_bit && (run_cnt >= LAST);
    end

    p_run_bounded_r2: assert property (@(posedge clk) disable iff (!rst_n)
        run_cnt <= FULL);

    p_dom_restarts_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_stb && !bus_bit) |=> (run_cnt == '0));

endmodule

// File: rtl/can_arb_cmp.sv
// Bit comparator.
// Compares the level the node drives with the sampled bus level on a strobe.
// A recessive drive read as dominant inside the arbitration window is a loss.
// A dominant drive read as recessive at any time while driving is a bit error.
module can_arb_cmp (
    input  logic sample_stb,
    input  logic in_drive,
    input  logic in_arb,
    input  logic own_bit,
    input  logic bus_bit,
    output logic lose_now,
    output logic err_now
);
    // Mismatch classification for the current strobe.
    always_comb begin
        lose_now = sample_stb && in_arb && own_bit && !bus_bit;
        err_now  = sample_stb && in_drive && !own_bit && bus_bit;
    end
endmodule

// File: rtl/can_arb_fsm.sv
// Arbitration sequencer.
// Holds the node role, counts arbitration bits after the start of frame and
// registers the loss and bit-error pulses. Moves only on sample strobes.
module can_arb_fsm
    import can_arb_pkg::*;
#(
    parameter int ARB_BITS = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sample_stb,
    input  logic       bus_bit,
    input  logic       tx_req,
    input  logic       run_fill,
    input  logic       lose_now,
    input  logic       err_now,
    output arb_state_t state,
    output logic       in_arb,
    output logic       arb_lost,
    output logic       bit_err
);
    localparam int AW = $clog2(ARB_BITS + 1);
    localparam logic [AW-1:0] ARB_END = AW'(ARB_BITS);

    logic [AW-1:0] arb_idx;

    // Role transitions and arbitration bit position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_LISTEN;
            arb_idx <= '0;
        end else if (sample_stb) begin
            case (state)
                ST_LISTEN: begin
                    if (run_fill) state <= ST_IDLE;
                end
                ST_IDLE: begin
                    if (tx_req) begin
                        state   <= ST_TX;
                        arb_idx <= '0;
                    end else if (!bus_bit) begin
                        state <= ST_LISTEN;
                    end
                end
                ST_TX: begin
                    if (lose_now)
                        state <= ST_LISTEN;
                    else if (run_fill)
                        state <= ST_IDLE;
                    if (arb_idx != ARB_END)
                        arb_idx <= arb_idx + 1'b1;
                end
                default: state <= ST_LISTEN;
            endcase
        end
    end

    // One-clock event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arb_lost <= 1'b0;
            bit_err  <= 1'b0;
        end else begin
            arb_lost <= lose_now;
            bit_err  <= err_now;
        end
    end

    // Arbitration window: the bits right after the start of frame.
    always_comb begin
        in_arb = (state == ST_TX) && (arb_idx < ARB_END);
    end

    p_lost_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        arb_lost |=> !arb_lost);

    p_lost_listens_r6: assert property (@(posedge clk) disable iff (!rst_n)
        arb_lost |-> (state == ST_LISTEN));

    p_tx_from_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TX && $past(state) != ST_TX) |-> ($past(state) == ST_IDLE));

    p_no_strobe_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sample_stb) |-> $stable(state));

endmodule

// File: rtl/can_arb_unit.sv
// Bitwise bus arbitration unit (top).
// Lets one node contend for a wired-AND serial bus (0 dominant). Assumes an
// external bit timer supplies single-cycle sample strobes with the sampled
// bus level, and that the serializer stuffs bits so a frame never holds 11
// recessive bits in a row before its end.
module can_arb_unit
    import can_arb_pkg::*;
#(
    parameter int IDLE_BITS = 11,
    parameter int ARB_BITS  = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sample_stb,
    input  logic bus_bit,
    input  logic tx_req,
    input  logic tx_bit,
    output logic drive_bit,
    output logic tx_enable,
    output logic bus_idle,
    output logic arb_lost,
    output logic bit_err
);
    arb_state_t state;
    logic       run_fill;
    logic       in_arb;
    logic       lose_now;
    logic       err_now;
    logic       sof_phase;

    can_arb_idle_det #(.IDLE_BITS(IDLE_BITS)) u_idle (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_stb (sample_stb),
        .bus_bit    (bus_bit),
        .run_fill   (run_fill)
    );

    can_arb_cmp u_cmp (
        .sample_stb (sample_stb),
        .in_drive   (tx_enable),
        .in_arb     (in_arb),
        .own_bit    (drive_bit),
        .bus_bit    (bus_bit),
        .lose_now   (lose_now),
        .err_now    (err_now)
    );

    can_arb_fsm #(.ARB_BITS(ARB_BITS)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_stb (sample_stb),
        .bus_bit    (bus_bit),
        .tx_req     (tx_req),
        .run_fill   (run_fill),
        .lose_now   (lose_now),
        .err_now    (err_now),
        .state      (state),
        .in_arb     (in_arb),
        .arb_lost   (arb_lost),
        .bit_err    (bit_err)
    );

    // Drive gating: dominant start bit when idle and requested, frame bits
    // while transmitting, recessive otherwise.
    always_comb begin
        sof_phase = (state == ST_IDLE) && tx_req;
        tx_enable = sof_phase || (state == ST_TX);
        bus_idle  = (state == ST_IDLE);
        if (state == ST_TX)
            drive_bit = tx_bit;
        else if (sof_phase)
            drive_bit = 1'b0;
        else
            drive_bit = 1'b1;
    end

    p_quiet_recessive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_enable |-> drive_bit);

    p_start_needs_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_enable) |-> bus_idle);

    p_lost_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        arb_lost |-> ($past(sample_stb) && $past(tx_bit) && !$past(bus_bit)));

    p_err_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bit_err |-> ($past(bus_bit) && !$past(drive_bit) && !arb_lost));

    p_idle_after_recessive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_idle) |-> ($past(sample_stb) && $past(bus_bit)));

endmodule

// File: tb/can_arb_unit_tb.sv
module can_arb_unit_tb;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sample_stb = 1'b0;
    logic tx_req = 1'b0;
    logic tx_bit = 1'b1;
    logic other_bit = 1'b1;
    logic inj_en = 1'b0;
    logic inj_val = 1'b1;
    logic bus_bit;
    logic drive_bit, tx_enable, bus_idle, arb_lost, bit_err;

    int checks = 0;
    int fails = 0;
    logic s_lost, s_err, s_en, s_idle;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Wired-AND bus with an optional override for fault injection.
    assign bus_bit = inj_en ? inj_val : (drive_bit & other_bit);

    can_arb_unit u_dut (
        .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb), .bus_bit(bus_bit),
        .tx_req(tx_req), .tx_bit(tx_bit), .drive_bit(drive_bit),
        .tx_enable(tx_enable), .bus_idle(bus_idle), .arb_lost(arb_lost),
        .bit_err(bit_err)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
        end
    endtask

    // One bit time: present bits, strobe for one clock, sample after the edge.
    task automatic step(input logic tb, input logic ob);
        @(negedge clk);
        tx_bit = tb;
        other_bit = ob;
        sample_stb = 1'b1;
        @(negedge clk);
        sample_stb = 1'b0;
        s_lost = arb_lost;
        s_err = bit_err;
        s_en = tx_enable;
        s_idle = bus_idle;
    endtask

    task automatic recessive_run(input int n);
        for (int i = 0; i < n; i++) step(1'b1, 1'b1);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 tx_enable", tx_enable, 1'b0);
        chk("R1 bus_idle", bus_idle, 1'b0);
        chk("R1 arb_lost", arb_lost, 1'b0);
        chk("R1 bit_err", bit_err, 1'b0);
        chk("R1 drive_bit", drive_bit, 1'b1);
    endtask

    task automatic t_idle_detect();
        recessive_run(10);
        chk("R2 not idle after 10", s_idle, 1'b0);
        step(1'b1, 1'b1);
        chk("R2 idle after 11", s_idle, 1'b1);
    endtask

    task automatic t_no_strobe();
        @(negedge clk);
        other_bit = 1'b0;
        repeat (4) @(negedge clk);
        chk("R11 bus_idle held without strobe", bus_idle, 1'b1);
        other_bit = 1'b1;
        @(negedge clk);
        chk("R11 bus_idle still", bus_idle, 1'b1);
    endtask

    task automatic t_dominant_restart();
        step(1'b1, 1'b0);
        chk("R3 dominant clears idle", s_idle, 1'b0);
        recessive_run(5);
        step(1'b1, 1'b0);
        recessive_run(10);
        chk("R2 restart: 10 after dominant not idle", s_idle, 1'b0);
        step(1'b1, 1'b1);
        chk("R2 restart: idle after 11", s_idle, 1'b1);
    endtask

    task automatic t_sof_blocked();
        step(1'b1, 1'b0);
        @(negedge clk);
        tx_req = 1'b1;
        @(negedge clk);
        chk("R4 no enable when busy", tx_enable, 1'b0);
        chk("R4 recessive when busy", drive_bit, 1'b1);
        step(1'b0, 1'b1);
        chk("R4 still no enable", s_en, 1'b0);
        tx_req = 1'b0;
        recessive_run(11);
        chk("R2 idle again", s_idle, 1'b1);
    endtask

    // Start of frame plus arbitration against a modelled competitor.
    // Returns the arbitration index where this node lost, or -1.
    task automatic arb_frame(input logic [10:0] my_id, input logic my_rtr,
                             input logic [10:0] ot_id, input logic ot_rtr,
                             input logic ot_on, output int lost_at);
        logic ot_out;
        logic mb, ob, bus_e, exp_l, we_on;
        lost_at = -1;
        ot_out = 1'b0;
        we_on = 1'b1;
        @(negedge clk);
        tx_req = 1'b1;
        @(negedge clk);
        chk("R4 enable at idle", tx_enable, 1'b1);
        chk("R4 dominant start bit", drive_bit, 1'b0);
        step(1'b0, ot_on ? 1'b0 : 1'b1);
        tx_req = 1'b0;
        for (int i = 0; i < 12; i++) begin
            mb = (i < 11) ? my_id[10-i] : my_rtr;
            ob = (i < 11) ? ot_id[10-i] : ot_rtr;
            ob = (!ot_on || ot_out) ? 1'b1 : ob;
            bus_e = (we_on ? mb : 1'b1) & ob;
            exp_l = we_on && mb && !bus_e;
            if (ot_on && !ot_out && ob && !bus_e) ot_out = 1'b1;
            step(mb, ob);
            chk($sformatf("R5 arb_lost at bit %0d", i), s_lost, exp_l);
            if (exp_l) begin
                lost_at = i;
                we_on = 1'b0;
                chk("R5 enable drops with loss", s_en, 1'b0);
            end
        end
    endtask

    task automatic t_win();
        int la;
        arb_frame(11'h100, 1'b0, 11'h120, 1'b0, 1'b1, la);
        chk("R9 no loss for lower id", la == -1, 1'b1);
        chk("R9 enable kept", s_en, 1'b1);
        @(negedge clk);
        tx_bit = 1'b0;
        #1;
        chk("R9 drive follows tx_bit 0", drive_bit, 1'b0);
        step(1'b0, 1'b1);
        step(1'b1, 1'b0);
        chk("R8 no loss in ack slot", s_lost, 1'b0);
        chk("R8 no bit error in ack slot", s_err, 1'b0);
        chk("R8 enable stays", s_en, 1'b1);
        recessive_run(10);
        chk("R10 enable before 11th", s_en, 1'b1);
        step(1'b1, 1'b1);
        chk("R10 enable drops at frame end", s_en, 1'b0);
        chk("R10 idle at frame end", s_idle, 1'b1);
    endtask

    task automatic t_lose();
        int la;
        arb_frame(11'h120, 1'b0, 11'h100, 1'b0, 1'b1, la);
        chk("R5 lost at id bit 5", la == 5, 1'b1);
        @(negedge clk);
        tx_bit = 1'b0;
        #1;
        chk("R6 recessive after loss", drive_bit, 1'b1);
        step(1'b0, 1'b0);
        chk("R6 enable off after loss", s_en, 1'b0);
        recessive_run(11);
        chk("R6 idle after loss", s_idle, 1'b1);
        @(negedge clk);
        tx_req = 1'b1;
        #1;
        chk("R6 rearmed start", tx_enable, 1'b1);
        @(negedge clk);
        tx_req = 1'b0;
    endtask

    task automatic t_rtr_loss();
        int la;
        arb_frame(11'h2A5, 1'b1, 11'h2A5, 1'b0, 1'b1, la);
        chk("R5 lost on remote bit", la == 11, 1'b1);
        recessive_run(11);
        chk("R2 idle after rtr loss", s_idle, 1'b1);
    endtask

    task automatic t_bit_error();
        int la;
        arb_frame(11'h0F3, 1'b0, 11'h000, 1'b0, 1'b0, la);
        chk("R9 solo frame keeps bus", la == -1, 1'b1);
        @(negedge clk);
        inj_en = 1'b1;
        inj_val = 1'b1;
        step(1'b0, 1'b1);
        inj_en = 1'b0;
        chk("R7 bit error pulse", s_err, 1'b1);
        chk("R7 no loss on bit error", s_lost, 1'b0);
        chk("R7 still transmitting", s_en, 1'b1);
        @(negedge clk);
        chk("R7 pulse one clock", bit_err, 1'b0);
        step(1'b0, 1'b1);
        recessive_run(11);
        chk("R10 idle after solo frame", s_idle, 1'b1);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_reset();
        t_idle_detect();
        t_no_strobe();
        t_dominant_restart();
        t_sof_blocked();
        t_win();
        t_lose();
        t_rtr_loss();
        t_bit_error();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule